// File: doc/BRIEF.md
# Load-Adaptive Switching Frequency Controller

This block picks the switching-clock frequency code for one switched-capacitor converter. It runs from the converter's own clock and advances its slow loop only once every `DIV` converter cycles. Because the converter clock slows down at light load, the controller's own activity and power fall along with it. On each slow-loop tick, a main comparator result steps the code up or down by one. The mode input chooses which comparator steers the loop. During startup it is the comparator that holds the target drop across the first stage. In run mode it is the comparator that checks the regulated output against the reference.

Light load makes the slow loop sluggish, so two fast drop detectors provide a bypass. When an armed detector fires, the code jumps straight to its maximum, and the slow loop then walks it back down one step per tick. Each detector has to be reset periodically. The controller drives the two detector resets in a staggered sequence. A detector's output is only trusted once it has been out of reset for a full tick, and at every moment exactly one detector is trusted. The detector inputs are asynchronous and pass through two-flop synchronizers. The comparator and mode inputs are taken to be settled between converter clock edges. All pins are plain control and status levels. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `sc_freq_ctrl`

## Requirements
- R1: After reset, `freq_code` is 0, `det_a_rst` is 1 and `det_b_rst` is 0. Without a drop event, `freq_code` changes only on the converter clock edge that ends each group of `DIV` cycles after reset release (a tick).
- R2: With `mode_run`=1, each tick raises `freq_code` by one if `cmp_run_low`=1 and lowers it by one if `cmp_run_low`=0; `cmp_start_low` has no effect.
- R3: With `mode_run`=0, each tick raises `freq_code` by one if `cmp_start_low`=1 and lowers it by one if `cmp_start_low`=0; `cmp_run_low` has no effect.
- R4: Stepping saturates: a step up at the maximum code (all ones, 31 at default width) and a step down at 0 leave the code unchanged.
- R5: A detector input held high while that detector is trusted sets `freq_code` to the maximum on the third converter clock edge after the input rises, whether or not that edge is a tick.
- R6: A drop event takes priority over a slow-loop step on the same edge. Once the detector input has fallen, later ticks step down from the maximum, one code per tick.
- R7: The reset schedule is measured in ticks. Detector A is held in reset for `SWAP_TICKS` ticks, then both resets are low for one tick, then detector B is held in reset for `SWAP_TICKS` ticks, then both are low for one tick, and the sequence repeats. The two resets are never high together.
- R8: A detector's input is ignored while its reset is high and during the one tick after its reset falls. At every moment exactly one detector is trusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| conv_clk | input | 1 | Converter switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_run | input | 1 | 0 selects startup comparator, 1 selects run comparator |
| cmp_start_low | input | 1 | Startup comparator: first-stage drop below target |
| cmp_run_low | input | 1 | Run comparator: output below reference |
| det_a_raw | input | 1 | Asynchronous drop detector A output |
| det_b_raw | input | 1 | Asynchronous drop detector B output |
| freq_code | output | CODE_W | Oscillator frequency code |
| det_a_rst | output | 1 | Reset for drop detector A |
| det_b_rst | output | 1 | Reset for drop detector B |

## Verification
The fast drop override and the slow-loop step can both act on the same tick edge. The bench provokes this by raising a trusted detector at the start of a tick window and lowering it only after the code has reached the maximum. The synchronized level is then still high at the tick edge, where the comparator asks for a step down. The result is judged by the code holding the maximum at that tick and dropping by exactly one at the following tick. A second overlap is a detector pulse that lands inside the guard tick after a reset release, and the bench expects that pulse to leave the code on its slow-loop value.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned NUM_DET = 2;

  // Detector schedule state: which detector is parked in reset, and
  // whether both are currently released (hand-over tick).
  typedef struct packed {
    logic parked;
    logic handover;
  } sched_st_t;
endpackage

// File: rtl/sfc_tick_gen.sv
module sfc_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfc_sync2.sv
module sfc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sfc_det_sched.sv
module sfc_det_sched
  import sfc_pkg::*;
#(
  parameter int unsigned SWAP_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output logic [NUM_DET-1:0] det_rst,
  output logic [NUM_DET-1:0] det_valid
);
  localparam int unsigned CW = $clog2(SWAP_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SWAP_TICKS - 1);

  sched_st_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.parked   <= 1'b0;
      st.handover <= 1'b0;
      cnt         <= '0;
    end else if (tick) begin
      if (st.handover) begin
        // the released detector has served its guard tick: swap roles
        st.handover <= 1'b0;
        st.parked   <= ~st.parked;
      end else if (cnt == LAST) begin
        st.handover <= 1'b1;
        cnt         <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The detector indexed by 'parked' is held in reset (or guarded during
  // hand-over); the other one is the only trusted detector.
  always_comb begin
    for (int i = 0; i < NUM_DET; i++) begin
      det_rst[i]   = !st.handover && (st.parked == i[0]);
      det_valid[i] = (st.parked != i[0]);
    end
  end
endmodule

// File: rtl/sfc_code_loop.sv
module sfc_code_loop #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              drop_hit,
  input  logic              step_up,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic at_top, at_bottom;

  assign at_top    = (code == CODE_MAX);
  assign at_bottom = (code == CODE_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= CODE_MIN;
    end else if (drop_hit) begin
      code <= CODE_MAX;
    end else if (tick) begin
      if (step_up && !at_top)         code <= code + 1'b1;
      else if (!step_up && !at_bottom) code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/sc_freq_ctrl.sv
module sc_freq_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned DIV        = 4,
  parameter int unsigned SWAP_TICKS = 8,
  parameter int unsigned CODE_W     = 5
) (
  input  logic              conv_clk,
  input  logic              rst_n,
  input  logic              mode_run,
  input  logic              cmp_start_low,
  input  logic              cmp_run_low,
  input  logic              det_a_raw,
  input  logic              det_b_raw,
  output logic [CODE_W-1:0] freq_code,
  output logic              det_a_rst,
  output logic              det_b_rst
);
  logic               tick;
  logic               step_up;
  logic               drop_hit;
  logic [NUM_DET-1:0] det_raw;
  logic [NUM_DET-1:0] det_sync;
  logic [NUM_DET-1:0] det_rst;
  logic [NUM_DET-1:0] det_valid;

  assign det_raw   = {det_b_raw, det_a_raw};
  assign det_a_rst = det_rst[0];
  assign det_b_rst = det_rst[1];

  sfc_tick_gen #(.DIV(DIV)) tick_i (
    .clk   (conv_clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar g = 0; g < NUM_DET; g++) begin : g_sync
    sfc_sync2 sync_i (
      .clk   (conv_clk),
      .rst_n (rst_n),
      .d     (det_raw[g]),
      .q     (det_sync[g])
    );
  end

  sfc_det_sched #(.SWAP_TICKS(SWAP_TICKS)) sched_i (
    .clk       (conv_clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .det_rst   (det_rst),
    .det_valid (det_valid)
  );

  assign step_up  = mode_run ? cmp_run_low : cmp_start_low;
  assign drop_hit = |(det_sync & det_valid);

  sfc_code_loop #(.CODE_W(CODE_W)) loop_i (
    .clk      (conv_clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .drop_hit (drop_hit),
    .step_up  (step_up),
    .code     (freq_code)
  );
endmodule

// File: rtl/sc_freq_ctrl_chk.sv
module sc_freq_ctrl_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              drop_hit,
  input logic              step_up,
  input logic [CODE_W-1:0] freq_code,
  input logic              det_a_rst,
  input logic              det_b_rst,
  input logic [1:0]        det_valid
);
  localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

  assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !drop_hit) |=> $stable(freq_code));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !drop_hit && step_up && freq_code != CMAX) |=>
      (freq_code == CODE_W'($past(freq_code) + 1'b1)));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !drop_hit && !step_up && freq_code != '0) |=>
      (freq_code == CODE_W'($past(freq_code) - 1'b1)));

  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step_up && freq_code == CMAX) |=> (freq_code == CMAX));

  assert_sat_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !drop_hit && !step_up && freq_code == '0) |=> (freq_code == '0));

  assert_drop_forces_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_hit |=> (freq_code == CMAX));

  assert_resets_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_a_rst && det_b_rst));

  assert_one_trusted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(det_valid) == 1);

  assert_reset_masks_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    det_a_rst |-> !det_valid[0]);

  assert_reset_masks_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    det_b_rst |-> !det_valid[1]);
endmodule

bind sc_freq_ctrl sc_freq_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
  .clk       (conv_clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .drop_hit  (drop_hit),
  .step_up   (step_up),
  .freq_code (freq_code),
  .det_a_rst (det_a_rst),
  .det_b_rst (det_b_rst),
  .det_valid (det_valid)
);

// File: tb/sc_freq_ctrl_tb_top.sv
module sc_freq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int SWAP_TICKS = 8;
  localparam int CODE_W     = 5;
  localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

  logic              conv_clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_run = 1'b0;
  logic              cmp_start_low = 1'b0;
  logic              cmp_run_low = 1'b0;
  logic              det_a_raw = 1'b0;
  logic              det_b_raw = 1'b0;
  logic [CODE_W-1:0] freq_code;
  logic              det_a_rst, det_b_rst;

  int checks = 0;
  int failures = 0;
  int n_ticks = 0;
  logic [CODE_W-1:0] exp_code = '0;
  bit done = 0;

  typedef struct {
    logic [CODE_W-1:0] code;
    logic              ra;
    logic              rb;
    string             tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) conv_clk = ~conv_clk;

  sc_freq_ctrl #(.DIV(DIV), .SWAP_TICKS(SWAP_TICKS), .CODE_W(CODE_W)) dut_i (
    .conv_clk      (conv_clk),
    .rst_n         (rst_n),
    .mode_run      (mode_run),
    .cmp_start_low (cmp_start_low),
    .cmp_run_low   (cmp_run_low),
    .det_a_raw     (det_a_raw),
    .det_b_raw     (det_b_raw),
    .freq_code     (freq_code),
    .det_a_rst     (det_a_rst),
    .det_b_rst     (det_b_rst)
  );

  // Schedule from R7: period of SWAP_TICKS+1 ticks per detector.
  function automatic logic model_rst(input int n, input int idx);
    int  per = SWAP_TICKS + 1;
    bit  parked = ((n / per) % 2) != 0;
    bit  hand = (n % per) == SWAP_TICKS;
    return !hand && (parked == idx[0]);
  endfunction

  task automatic expect_now(input string tag);
    exp_t e;
    e.code = exp_code;
    e.ra   = model_rst(n_ticks, 0);
    e.rb   = model_rst(n_ticks, 1);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic cycles(input int k);
    repeat (k) @(posedge conv_clk);
    @(negedge conv_clk);
  endtask

  task automatic tick_step(input logic run, input logic c_start, input logic c_run,
                           input string tag);
    logic up;
    mode_run = run; cmp_start_low = c_start; cmp_run_low = c_run;
    cycles(DIV);
    n_ticks++;
    up = run ? c_run : c_start;
    if (up && exp_code != CMAX) exp_code = exp_code + 1'b1;
    else if (!up && exp_code != '0) exp_code = exp_code - 1'b1;
    expect_now(tag);
  endtask

  // Monitor: pops expected items and compares with the ports.
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      checks++;
      if (freq_code !== e.code || det_a_rst !== e.ra || det_b_rst !== e.rb) begin
        failures++;
        $display("FAIL %s: code=%0d rst_a=%b rst_b=%b expected code=%0d rst_a=%b rst_b=%b",
                 e.tag, freq_code, det_a_rst, det_b_rst, e.code, e.ra, e.rb);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge conv_clk);
    rst_n = 1'b1;
    expect_now("R1 reset state");

    // R1: no change before the tick edge, then one step on it
    mode_run = 1'b1; cmp_run_low = 1'b1;
    cycles(DIV - 1);
    expect_now("R1 hold before tick");
    cycles(1);
    n_ticks++; exp_code = 1;
    expect_now("R1 step on tick");

    // R2: run mode, startup comparator held opposite
    for (int i = 0; i < 5; i++) tick_step(1'b1, 1'b0, 1'b1, "R2 run up");
    for (int i = 0; i < 3; i++) tick_step(1'b1, 1'b1, 1'b0, "R2 run down");

    // R3: startup mode, run comparator held opposite
    for (int i = 0; i < 2; i++) tick_step(1'b0, 1'b1, 1'b0, "R3 start up");
    tick_step(1'b0, 1'b0, 1'b1, "R3 start down");

    // R4: saturate at zero
    for (int i = 0; i < 7; i++) tick_step(1'b0, 1'b0, 1'b1, "R4 floor");

    // R8: detector A is in reset; its pulse must not move the code
    det_a_raw = 1'b1;
    tick_step(1'b0, 1'b0, 1'b0, "R8 parked detector ignored");
    det_a_raw = 1'b0;
    tick_step(1'b0, 1'b0, 1'b0, "R8 parked detector ignored");

    // R5/R6: trusted detector B fires; collides with a tick edge
    mode_run = 1'b1; cmp_run_low = 1'b0;
    det_b_raw = 1'b1;
    cycles(3);
    exp_code = CMAX;
    expect_now("R5 drop B forces max");
    det_b_raw = 1'b0;
    cycles(1);
    n_ticks++;
    expect_now("R6 drop wins over step");
    tick_step(1'b1, 1'b0, 1'b0, "R6 walk down after drop");

    // R4: saturate at maximum
    tick_step(1'b1, 1'b0, 1'b1, "R4 up to max");
    tick_step(1'b1, 1'b0, 1'b1, "R4 ceiling");

    // R7: reach the hand-over tick, both resets low
    tick_step(1'b1, 1'b0, 1'b0, "R7 before hand-over");

    // R8: pulse on A inside its guard tick is ignored; R7 swap to B parked
    det_a_raw = 1'b1;
    cycles(1);
    det_a_raw = 1'b0;
    cycles(DIV - 1);
    n_ticks++;
    exp_code = exp_code - 1'b1;
    expect_now("R8 guard tick ignored, R7 B parked");

    // R5: detector A now trusted
    det_a_raw = 1'b1;
    cycles(3);
    exp_code = CMAX;
    expect_now("R5 drop A forces max");
    det_a_raw = 1'b0;
    cycles(1);
    n_ticks++;
    expect_now("R6 drop A wins over step");
    tick_step(1'b1, 1'b0, 1'b0, "R6 walk down after drop A");

    // R7: one more full schedule period
    for (int i = 0; i < SWAP_TICKS + 1; i++) tick_step(1'b1, 1'b1, 1'b0, "R7 schedule");

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule